// File: doc/BRIEF.md
# Variable-Length FFT Operand Address Generator

This block drives the data memory of an in-place, memory-based decimation-in-frequency FFT engine whose processing element handles one radix-2² butterfly per cycle. For every butterfly it produces four operand addresses s, t, u and v. Each address is also given as a bank number and a row inside that bank, for a memory split four ways. The block also gives the twiddle exponents the processing element needs, in units of the longest supported transform. Transform lengths are powers of two, from 4 points up to 2^LOG2N points. The default LOG2N of 13 gives an 8192-point maximum, and the target engine uses it for 256 to 8192 points.

Addresses come from a butterfly counter and a stage counter. A multiplexer array, controlled by a decoder on the stage number, places a zero base-4 digit inside the counter value. Three OR masks then set that digit to 1, 2 and 3. When the length is not a power of four, the first stage runs in radix-2 mode. In that mode the counter steps by two and every address is shifted right by one bit, so the processing element performs two radix-2 butterflies, on the pairs (s,u) and (t,v). The host pulses `start_i` with the length code, then raises `adv_i` once per consumed butterfly. `done_o` marks the end of the transform.

Top module: `vlfft_agu`

## Requirements
- R1: While reset is held, and after it is released, `valid_o`, `done_o` and `radix2_o` are 0.
- R2: In radix-2² mode the block works with D = ceil(LOG2N/2) base-4 digits and a stage number k. Address s is the butterfly counter value with a 2-bit zero digit inserted at digit position D-1-k, counted from the least significant digit. Counter digits below that position keep their place, and counter digits above it move up one digit. t, u and v equal s with the inserted digit set to 1, 2 and 3. The four addresses are strictly ascending.
- R3: A pulse on `start_i` loads the length code L = log2(P), which must lie in 2..LOG2N. The stage starts at D - ceil(L/2) and the counter starts at 0. `valid_o` is high from the next cycle. Each cycle with `valid_o` and `adv_i` high consumes one butterfly. A radix-2² stage lasts P/4 advances with counter values 0 to P/4-1, then the stage rises by exactly one. Stage D-1 is the last stage.
- R4: When L is odd, the first stage runs in radix-2 mode with `radix2_o` = 1. The counter takes the even values 0, 2, ..., P/2-2, and every address is shifted right by one bit. All later stages use radix-2² mode. For an even L, `radix2_o` stays 0.
- R5: For each address, the bank is the sum of its base-4 digits modulo 4 and the row is the address shifted right by 2. Bank and row for s, t, u, v (index i = 0..3) sit at `bank_o[2i+1:2i]` and `row_o[i*(2D-2) +: 2D-2]`. The four banks of one cycle are all different.
- R6: In radix-2² mode, let n be the butterfly counter shifted left by 2k bits, truncated to 2D-2 bits. Then `tw1_o` = n, `tw2_o` = 2n and `tw3_o` = 3n.
- R7: In radix-2 mode, `tw1_o` = n, `tw2_o` = n + 4^(D-1) and `tw3_o` = 0.
- R8: The advance that consumes the last butterfly of stage D-1 drops `valid_o` and raises `done_o` for exactly one cycle.
- R9: While `adv_i` is low, the counters and all outputs hold. A `start_i` pulse in the middle of a transform restarts the block with the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load length and begin a transform |
| len_log2_i | input | $clog2(LOG2N+1) | log2 of the transform length |
| adv_i | input | 1 | Current butterfly consumed |
| valid_o | output | 1 | Addresses and exponents are meaningful |
| done_o | output | 1 | One-cycle end-of-transform pulse |
| radix2_o | output | 1 | Radix-2 first-stage mode |
| addr_s_o | output | 2D | Operand address s |
| addr_t_o | output | 2D | Operand address t |
| addr_u_o | output | 2D | Operand address u |
| addr_v_o | output | 2D | Operand address v |
| tw1_o | output | 2D | First twiddle exponent |
| tw2_o | output | 2D | Second twiddle exponent |
| tw3_o | output | 2D | Third twiddle exponent |
| bank_o | output | 8 | Bank numbers for s, t, u, v |
| row_o | output | 4(2D-2) | In-bank rows for s, t, u, v |

## Verification
The bench builds two instances. One uses LOG2N = 4, a 16-point maximum with two digits, and there the 16-, 8- and 4-point sequences are compared against hand-written vectors, including the radix-2 pairs and the single-butterfly 4-point case. The other uses the default LOG2N = 13, seven digits and a 12-bit counter. It is run through every length from 256 to 8192 points against an arithmetic model built on group and offset rather than digit insertion. This covers the odd-length radix-2 first stage with the 4094 counter limit, the rounded-down start stages and the truncation of the twiddle exponent.

// File: rtl/vlfft_agu_pkg.sv
package vlfft_agu_pkg;

  typedef enum logic [1:0] {
    MUX_BYPASS = 2'd0,
    MUX_INSERT = 2'd1,
    MUX_SHIFT  = 2'd2
  } mux_sel_e;

  // First stage index for a 2^len transform inside a d-digit space
  function automatic int start_stage(input int d, input int len);
    return d - ((len + 1) >> 1);
  endfunction

endpackage

// File: rtl/vlfft_agu_seq.sv
module vlfft_agu_seq import vlfft_agu_pkg::*; #(
  parameter int LOG2N = 13,
  localparam int D  = (LOG2N + 1) / 2,
  localparam int BW = 2 * D - 2,
  localparam int SW = $clog2(D + 1),
  localparam int LW = $clog2(LOG2N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] len_log2_i,
  input  logic          adv_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          r2_o,
  output logic [SW-1:0] stage_o,
  output logic [BW-1:0] bf_o
);

  logic          busy_q, done_q, r2_q;
  logic [LW-1:0] len_q;
  logic [SW-1:0] stage_q, stage_init;
  logic [BW-1:0] bf_q, bf_last, bf_step;
  logic [BW:0]   span;
  logic          at_last, last_stage;

  assign stage_init = SW'(start_stage(D, int'(len_log2_i)));

  // radix-2 stage ends at 2^(L-1)-2, radix-2^2 stage at 2^(L-2)-1
  assign span       = (BW+1)'(1) << (len_q - (r2_q ? LW'(1) : LW'(2)));
  assign bf_last    = BW'(span - (r2_q ? (BW+1)'(2) : (BW+1)'(1)));
  assign bf_step    = r2_q ? BW'(2) : BW'(1);
  assign at_last    = (bf_q == bf_last);
  assign last_stage = (stage_q == SW'(D - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      r2_q    <= 1'b0;
      len_q   <= '0;
      stage_q <= '0;
      bf_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q  <= 1'b1;
        len_q   <= len_log2_i;
        stage_q <= stage_init;
        bf_q    <= '0;
        r2_q    <= len_log2_i[0];
      end else if (busy_q && adv_i) begin
        if (at_last) begin
          bf_q <= '0;
          r2_q <= 1'b0;
          if (last_stage) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            stage_q <= stage_q + 1'b1;
          end
        end else begin
          bf_q <= bf_q + bf_step;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign r2_o    = r2_q;
  assign stage_o = stage_q;
  assign bf_o    = bf_q;

  AST_STAGE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (stage_q < SW'(D))) else $error("stage out of range"); // R3

  AST_STAGE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && adv_i && !start_i && at_last && !last_stage) |=>
    (stage_q == $past(stage_q) + 1'b1)) else $error("stage did not step by one"); // R3

  AST_R2_FIRST_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r2_q |-> (busy_q && len_q[0] && stage_q == SW'(start_stage(D, int'(len_q)))))
    else $error("radix-2 mode outside first stage"); // R4

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q) else $error("done longer than one cycle"); // R8

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !adv_i && !start_i) |=> ($stable(bf_q) && $stable(stage_q)))
    else $error("counters moved without advance"); // R9

endmodule

// File: rtl/vlfft_agu_sib.sv
module vlfft_agu_sib import vlfft_agu_pkg::*; #(
  parameter int LOG2N = 13,
  localparam int D  = (LOG2N + 1) / 2,
  localparam int VW = 2 * D,
  localparam int BW = VW - 2,
  localparam int SW = $clog2(D + 1)
) (
  input  logic [SW-1:0] stage_i,
  input  logic [BW-1:0] bf_i,
  output logic [VW-1:0] s_o,
  output logic [VW-1:0] t_o,
  output logic [VW-1:0] u_o,
  output logic [VW-1:0] v_o
);

  mux_sel_e      sel [D];   // index 0 drives the most significant digit
  logic [D-1:0]  ins;
  logic [VW-1:0] mask_lo, mask_hi;

  // stage k: muxes above k shift, mux k inserts, the rest bypass
  always_comb begin
    for (int m = 0; m < D; m++) begin
      if (SW'(m) < stage_i)       sel[m] = MUX_SHIFT;
      else if (SW'(m) == stage_i) sel[m] = MUX_INSERT;
      else                        sel[m] = MUX_BYPASS;
    end
  end

  for (genvar j = 0; j < D; j++) begin : g_digit
    localparam int M = D - 1 - j;
    logic [1:0] byp, shf;
    if (j < D - 1) begin : g_byp
      assign byp = bf_i[2*j +: 2];
    end else begin : g_byp_top
      assign byp = 2'b00;
    end
    if (j > 0) begin : g_shf
      assign shf = bf_i[2*(j-1) +: 2];
    end else begin : g_shf_bot
      assign shf = 2'b00;
    end
    assign s_o[2*j +: 2] = (sel[M] == MUX_SHIFT)  ? shf :
                           (sel[M] == MUX_INSERT) ? 2'b00 : byp;
    assign ins[j]          = (sel[M] == MUX_INSERT);
    assign mask_lo[2*j]    = ins[j];
    assign mask_lo[2*j+1]  = 1'b0;
    assign mask_hi[2*j]    = 1'b0;
    assign mask_hi[2*j+1]  = ins[j];
  end

  assign t_o = s_o | mask_lo;
  assign u_o = s_o | mask_hi;
  assign v_o = s_o | mask_lo | mask_hi;

  always_comb begin
    if (stage_i < SW'(D)) begin
      AST_ONE_INSERT: assert ($countones(ins) == 1) else $error("insert position not unique"); // R2
    end
  end

endmodule

// File: rtl/vlfft_agu_bank.sv
module vlfft_agu_bank #(
  parameter int LOG2N = 13,
  localparam int D  = (LOG2N + 1) / 2,
  localparam int VW = 2 * D,
  localparam int BW = VW - 2
) (
  input  logic [VW-1:0] addr_i,
  output logic [1:0]    bank_o,
  output logic [BW-1:0] row_o
);

  always_comb begin
    bank_o = 2'b00;
    for (int j = 0; j < D; j++) begin
      bank_o = bank_o + addr_i[2*j +: 2];
    end
  end

  assign row_o = addr_i[VW-1:2];

endmodule

// File: rtl/vlfft_agu_tw.sv
module vlfft_agu_tw #(
  parameter int LOG2N = 13,
  localparam int D  = (LOG2N + 1) / 2,
  localparam int VW = 2 * D,
  localparam int BW = VW - 2,
  localparam int SW = $clog2(D + 1)
) (
  input  logic [SW-1:0] stage_i,
  input  logic [BW-1:0] bf_i,
  input  logic          r2_i,
  output logic [VW-1:0] tw1_o,
  output logic [VW-1:0] tw2_o,
  output logic [VW-1:0] tw3_o
);

  logic [BW-1:0] n;
  logic [VW-1:0] n1, n2;

  assign n  = bf_i << {stage_i, 1'b0};
  assign n1 = {2'b00, n};
  assign n2 = {1'b0, n, 1'b0};

  assign tw1_o = n1;
  assign tw2_o = r2_i ? {2'b01, n} : n2;
  assign tw3_o = r2_i ? '0 : n2 + n1;

endmodule

// File: rtl/vlfft_agu.sv
module vlfft_agu import vlfft_agu_pkg::*; #(
  parameter int LOG2N = 13,
  localparam int D  = (LOG2N + 1) / 2,
  localparam int VW = 2 * D,
  localparam int BW = VW - 2,
  localparam int SW = $clog2(D + 1),
  localparam int LW = $clog2(LOG2N + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [LW-1:0]   len_log2_i,
  input  logic            adv_i,
  output logic            valid_o,
  output logic            done_o,
  output logic            radix2_o,
  output logic [VW-1:0]   addr_s_o,
  output logic [VW-1:0]   addr_t_o,
  output logic [VW-1:0]   addr_u_o,
  output logic [VW-1:0]   addr_v_o,
  output logic [VW-1:0]   tw1_o,
  output logic [VW-1:0]   tw2_o,
  output logic [VW-1:0]   tw3_o,
  output logic [7:0]      bank_o,
  output logic [4*BW-1:0] row_o
);

  logic          busy, r2;
  logic [SW-1:0] stage;
  logic [BW-1:0] bf;
  logic [VW-1:0] raw [4];
  logic [VW-1:0] addr [4];

  vlfft_agu_seq #(.LOG2N(LOG2N)) seq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .len_log2_i (len_log2_i),
    .adv_i      (adv_i),
    .busy_o     (busy),
    .done_o     (done_o),
    .r2_o       (r2),
    .stage_o    (stage),
    .bf_o       (bf)
  );

  vlfft_agu_sib #(.LOG2N(LOG2N)) sib_i (
    .stage_i (stage),
    .bf_i    (bf),
    .s_o     (raw[0]),
    .t_o     (raw[1]),
    .u_o     (raw[2]),
    .v_o     (raw[3])
  );

  vlfft_agu_tw #(.LOG2N(LOG2N)) tw_i (
    .stage_i (stage),
    .bf_i    (bf),
    .r2_i    (r2),
    .tw1_o   (tw1_o),
    .tw2_o   (tw2_o),
    .tw3_o   (tw3_o)
  );

  for (genvar i = 0; i < 4; i++) begin : g_port
    // radix-2 stage runs in a doubled space, folded back by one bit
    assign addr[i] = r2 ? (raw[i] >> 1) : raw[i];
    vlfft_agu_bank #(.LOG2N(LOG2N)) bank_i (
      .addr_i (addr[i]),
      .bank_o (bank_o[2*i +: 2]),
      .row_o  (row_o[i*BW +: BW])
    );
  end

  assign valid_o  = busy;
  assign radix2_o = r2;
  assign addr_s_o = addr[0];
  assign addr_t_o = addr[1];
  assign addr_u_o = addr[2];
  assign addr_v_o = addr[3];

  AST_ADDR_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (addr_s_o < addr_t_o && addr_t_o < addr_u_o && addr_u_o < addr_v_o))
    else $error("operand addresses not ascending"); // R2

  AST_BANK_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (bank_o[1:0] != bank_o[3:2] && bank_o[1:0] != bank_o[5:4] &&
                 bank_o[1:0] != bank_o[7:6] && bank_o[3:2] != bank_o[5:4] &&
                 bank_o[3:2] != bank_o[7:6] && bank_o[5:4] != bank_o[7:6]))
    else $error("bank conflict"); // R5

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!valid_o && !radix2_o)) else $error("done while busy"); // R8

endmodule

// File: tb/vlfft_agu_tb_top.sv
module vlfft_agu_tb_top;

  localparam int SD = 2, SVW = 4, SBW = 2, SLW = 3;
  localparam int BD = 7, BVW = 14, BBW = 12, BLW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  logic           sm_start = 1'b0, sm_adv = 1'b0;
  logic [SLW-1:0] sm_len = '0;
  logic           sm_valid, sm_done, sm_r2;
  logic [SVW-1:0] sm_s, sm_t, sm_u, sm_v, sm_tw1, sm_tw2, sm_tw3;
  logic [7:0]     sm_bank;
  logic [4*SBW-1:0] sm_row;

  logic           bg_start = 1'b0, bg_adv = 1'b0;
  logic [BLW-1:0] bg_len = '0;
  logic           bg_valid, bg_done, bg_r2;
  logic [BVW-1:0] bg_s, bg_t, bg_u, bg_v, bg_tw1, bg_tw2, bg_tw3;
  logic [7:0]     bg_bank;
  logic [4*BBW-1:0] bg_row;

  vlfft_agu #(.LOG2N(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(sm_start), .len_log2_i(sm_len), .adv_i(sm_adv),
    .valid_o(sm_valid), .done_o(sm_done), .radix2_o(sm_r2),
    .addr_s_o(sm_s), .addr_t_o(sm_t), .addr_u_o(sm_u), .addr_v_o(sm_v),
    .tw1_o(sm_tw1), .tw2_o(sm_tw2), .tw3_o(sm_tw3), .bank_o(sm_bank), .row_o(sm_row)
  );

  vlfft_agu #(.LOG2N(13)) dut_big_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(bg_start), .len_log2_i(bg_len), .adv_i(bg_adv),
    .valid_o(bg_valid), .done_o(bg_done), .radix2_o(bg_r2),
    .addr_s_o(bg_s), .addr_t_o(bg_t), .addr_u_o(bg_u), .addr_v_o(bg_v),
    .tw1_o(bg_tw1), .tw2_o(bg_tw2), .tw3_o(bg_tw3), .bank_o(bg_bank), .row_o(bg_row)
  );

  // first, len, k, bf, s, t, u, v, radix2
  localparam logic [24:0] VEC [13] = '{
    {1'b1, 3'd4, 2'd0, 2'd0, 4'd0,  4'd4,  4'd8,  4'd12, 1'b0},
    {1'b0, 3'd4, 2'd0, 2'd1, 4'd1,  4'd5,  4'd9,  4'd13, 1'b0},
    {1'b0, 3'd4, 2'd0, 2'd2, 4'd2,  4'd6,  4'd10, 4'd14, 1'b0},
    {1'b0, 3'd4, 2'd0, 2'd3, 4'd3,  4'd7,  4'd11, 4'd15, 1'b0},
    {1'b0, 3'd4, 2'd1, 2'd0, 4'd0,  4'd1,  4'd2,  4'd3,  1'b0},
    {1'b0, 3'd4, 2'd1, 2'd1, 4'd4,  4'd5,  4'd6,  4'd7,  1'b0},
    {1'b0, 3'd4, 2'd1, 2'd2, 4'd8,  4'd9,  4'd10, 4'd11, 1'b0},
    {1'b0, 3'd4, 2'd1, 2'd3, 4'd12, 4'd13, 4'd14, 4'd15, 1'b0},
    {1'b1, 3'd3, 2'd0, 2'd0, 4'd0,  4'd2,  4'd4,  4'd6,  1'b1},
    {1'b0, 3'd3, 2'd0, 2'd2, 4'd1,  4'd3,  4'd5,  4'd7,  1'b1},
    {1'b0, 3'd3, 2'd1, 2'd0, 4'd0,  4'd1,  4'd2,  4'd3,  1'b0},
    {1'b0, 3'd3, 2'd1, 2'd1, 4'd4,  4'd5,  4'd6,  4'd7,  1'b0},
    {1'b1, 3'd2, 2'd1, 2'd0, 4'd0,  4'd1,  4'd2,  4'd3,  1'b0}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint m_addr(input int d, input int k, input longint bf, input int dig, input bit r2);
    longint span, a;
    int q;
    q    = d - 1 - k;
    span = longint'(1) << (2 * q);
    a    = (bf / span) * (span * 4) + (bf % span) + dig * span;
    return r2 ? (a >> 1) : a;
  endfunction

  function automatic longint m_bank(input longint a);
    longint sum = 0;
    for (longint x = a; x != 0; x = x / 4) sum += x % 4;
    return sum % 4;
  endfunction

  function automatic longint m_n(input int d, input int k, input longint bf);
    longint span;
    span = longint'(1) << (2 * (d - 1 - k));
    return (bf % span) * (longint'(1) << (2 * k));
  endfunction

  task automatic expect_all(input int d, input int k, input longint bf, input bit r2,
                            input logic valid, input logic r2f,
                            input longint a0, input longint a1, input longint a2, input longint a3,
                            input logic [7:0] bank, input logic [63:0] row,
                            input longint tw1, input longint tw2, input longint tw3);
    longint act [4];
    longint ex, n;
    int bw;
    string areq;
    act  = '{a0, a1, a2, a3};
    bw   = 2 * d - 2;
    areq = r2 ? "R4" : "R2";
    chk("R3", "valid", valid, 1);
    chk("R4", "radix2 flag", r2f, r2);
    for (int i = 0; i < 4; i++) begin
      ex = m_addr(d, k, bf, i, r2);
      chk(areq, $sformatf("addr%0d k=%0d bf=%0d", i, k, bf), act[i], ex);
      chk("R5", $sformatf("bank%0d", i), longint'(bank[2*i +: 2]), m_bank(ex));
      chk("R5", $sformatf("row%0d", i), longint'((row >> (i * bw)) & ((64'd1 << bw) - 1)), ex / 4);
    end
    n = m_n(d, k, bf);
    if (r2) begin
      chk("R7", "tw1", tw1, n);
      chk("R7", "tw2", tw2, n + (longint'(1) << bw));
      chk("R7", "tw3", tw3, 0);
    end else begin
      chk("R6", "tw1", tw1, n);
      chk("R6", "tw2", tw2, 2 * n);
      chk("R6", "tw3", tw3, 3 * n);
    end
  endtask

  task automatic sm_expect(input int k, input int bf, input bit r2);
    expect_all(SD, k, bf, r2, sm_valid, sm_r2, sm_s, sm_t, sm_u, sm_v,
               sm_bank, 64'(sm_row), sm_tw1, sm_tw2, sm_tw3);
  endtask

  task automatic bg_expect(input int k, input int bf, input bit r2);
    expect_all(BD, k, bf, r2, bg_valid, bg_r2, bg_s, bg_t, bg_u, bg_v,
               bg_bank, 64'(bg_row), bg_tw1, bg_tw2, bg_tw3);
  endtask

  task automatic sm_go(input int len);
    @(negedge clk);
    sm_len = SLW'(len);
    sm_start = 1'b1;
    @(negedge clk);
    sm_start = 1'b0;
  endtask

  task automatic bg_go(input int len);
    @(negedge clk);
    bg_len = BLW'(len);
    bg_start = 1'b1;
    @(negedge clk);
    bg_start = 1'b0;
  endtask

  task automatic sm_step();
    sm_adv = 1'b1;
    @(negedge clk);
    sm_adv = 1'b0;
  endtask

  task automatic bg_step();
    bg_adv = 1'b1;
    @(negedge clk);
    bg_adv = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R3 watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1", "valid in reset", sm_valid, 0);
    chk("R1", "done in reset", sm_done, 0);
    chk("R1", "radix2 in reset", bg_r2, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid after reset", bg_valid, 0);
    chk("R1", "done after reset", bg_done, 0);

    // R2 R4: 16-, 8- and 4-point sequences from the vector table
    for (int i = 0; i < 13; i++) begin
      if (VEC[i][24]) sm_go(int'(VEC[i][23:21]));
      chk(VEC[i][0] ? "R4" : "R2", "s vec", sm_s, VEC[i][16:13]);
      chk(VEC[i][0] ? "R4" : "R2", "t vec", sm_t, VEC[i][12:9]);
      chk(VEC[i][0] ? "R4" : "R2", "u vec", sm_u, VEC[i][8:5]);
      chk(VEC[i][0] ? "R4" : "R2", "v vec", sm_v, VEC[i][4:1]);
      sm_expect(int'(VEC[i][20:19]), int'(VEC[i][18:17]), VEC[i][0]);
      sm_step();
      if (i == 12 || VEC[(i + 1) % 13][24]) begin
        chk("R8", "done pulse", sm_done, 1);
        chk("R8", "valid after end", sm_valid, 0);
        @(negedge clk);
        chk("R8", "done one cycle", sm_done, 0);
      end
    end

    // R9: hold without advance, then restart mid-transform
    sm_go(4);
    repeat (3) @(negedge clk);
    sm_expect(0, 0, 1'b0);
    sm_step();
    sm_expect(0, 1, 1'b0);
    sm_go(2);
    chk("R9", "restart s", sm_s, 0);
    chk("R9", "restart v", sm_v, 3);
    sm_expect(1, 0, 1'b0);
    sm_step();
    chk("R9", "restart done", sm_done, 1);

    // R3 R4 R5 R6 R7: every supported length on the full-size instance
    for (int len = 8; len <= 13; len++) begin
      int k0;
      bg_go(len);
      k0 = BD - ((len + 1) / 2);
      for (int k = k0; k < BD; k++) begin
        bit r2;
        int step, cnt;
        r2   = (k == k0) && (len % 2 == 1);
        step = r2 ? 2 : 1;
        cnt  = r2 ? (1 << (len - 1)) : (1 << (len - 2));
        for (int bf = 0; bf < cnt; bf += step) begin
          bg_expect(k, bf, r2);
          bg_step();
        end
      end
      chk("R8", $sformatf("done len=%0d", len), bg_done, 1);
      chk("R3", $sformatf("idle len=%0d", len), bg_valid, 0);
    end

    summary();
    $finish;
  end

endmodule